// File: doc/BRIEF.md
# Streaming array sum and extremum unit

The block walks a table of unsigned 8-bit elements held in a synchronous single-port memory. It reads one location per clock and folds each returned word into a sum through a single adder. The accumulator is wide enough that the largest possible total cannot overflow. In the same pass it keeps the largest and the smallest element seen, together with the position of each. The pass produces one set of results: the total, the maximum value and its index, and the minimum value and its index, marked by a one-cycle completion pulse.

A pass begins on a start pulse while the unit is idle. The unit drives a read strobe and an address. The memory returns the addressed word on the next cycle, so the accumulate stage runs one cycle behind the address counter. The running sum and the extremum registers are loaded from the first element, not from preset constants. The table can be rewritten between passes, and every pass reads it again.

Top module: `array_stat_scan`

## Requirements
- R1: Elements are 8-bit unsigned words. For N elements the sum output is 8 + ceil(log2(N)) bits wide and the address and index outputs are ceil(log2(N)) bits wide, at least 1 bit. For the default N = 100 these are 15 and 7 bits.
- R2: After a start is accepted, mem_rd_o is high for exactly N consecutive cycles. mem_addr_o runs 0, 1, ..., N-1, rising by one each cycle. The data word for an address is taken from mem_data_i on the cycle after that address is presented.
- R3: With N = 100 and every element equal to 0xFF, sum_o equals 0x639C exactly, with no wrap.
- R4: At the done pulse, sum_o equals the arithmetic total of all N elements.
- R5: At the done pulse, max_o holds the largest element. max_idx_o holds the lowest index at which that value occurs.
- R6: At the done pulse, min_o holds the smallest element. min_idx_o holds the lowest index at which that value occurs.
- R7: done_o is high for exactly one cycle. It rises at the (N+1)-th rising clock edge after the edge that accepts start.
- R8: From the done pulse until the next accepted start, sum_o, max_o, max_idx_o, min_o and min_idx_o do not change.
- R9: A start pulse that arrives while a pass is in progress has no effect. The addresses, the results and the done timing are the same as without it.
- R10: While rst_n is low, every output is zero. A reset during a pass abandons it, and no done pulse follows.
- R11: Each pass reads the memory again. New table contents written between passes give results that match the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a pass, taken only when idle |
| mem_rd_o | output | 1 | Read strobe to the table memory |
| mem_addr_o | output | AW (7) | Element address being read |
| mem_data_i | input | DW (8) | Word returned one cycle after the address |
| sum_o | output | SW (15) | Total of all elements |
| max_o | output | DW (8) | Largest element |
| max_idx_o | output | AW (7) | Lowest index holding the largest element |
| min_o | output | DW (8) | Smallest element |
| min_idx_o | output | AW (7) | Lowest index holding the smallest element |
| done_o | output | 1 | One-cycle pulse when results are final |

## Verification
The hardest case to reach from the ports is a start request that lands in the middle of a pass. It has to arrive while the read pipeline is full, at a point where a wrong restart would shift the addresses and change every result. The bench raises start partway through selected runs and checks that the totals, the extremum positions and the exact done cycle all match a clean run. The tie rule is driven by tables with repeated maxima and minima at late positions. A reset is also dropped into a running pass to show that the pass is abandoned.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic {
    FETCH_IDLE = 1'b0,
    FETCH_RUN  = 1'b1
  } fetch_state_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int sum_width(input int dw, input int n);
    return dw + ((n > 1) ? $clog2(n) : 0);
  endfunction

endpackage

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
  import scan_pkg::*;
#(
  parameter int N_ELEM = 100,
  parameter int AW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_i,
  output logic          rd_o,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(N_ELEM - 1);

  fetch_state_e  state_q, state_n;
  logic [AW-1:0] addr_q, addr_n;

  always_comb begin
    state_n = state_q;
    addr_n  = addr_q;
    case (state_q)
      FETCH_IDLE: begin
        if (launch_i) begin
          state_n = FETCH_RUN;
          addr_n  = '0;
        end
      end
      FETCH_RUN: begin
        if (addr_q == LAST_ADDR) begin
          state_n = FETCH_IDLE;
        end else begin
          addr_n = addr_q + AW'(1);
        end
      end
      default: state_n = FETCH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FETCH_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_n;
      addr_q  <= addr_n;
    end
  end

  assign rd_o   = (state_q == FETCH_RUN);
  assign addr_o = addr_q;
  assign last_o = rd_o && (addr_q == LAST_ADDR);

endmodule

// File: rtl/scan_accum.sv
module scan_accum #(
  parameter int DW = 8,
  parameter int SW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic          first_i,
  input  logic [DW-1:0] data_i,
  output logic [SW-1:0] sum_o
);

  logic [SW-1:0] sum_q, sum_n;
  logic [SW-1:0] addend;

  assign addend = SW'(data_i);

  always_comb begin
    sum_n = sum_q;
    if (valid_i) begin
      sum_n = first_i ? addend : (sum_q + addend);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else begin
      sum_q <= sum_n;
    end
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/scan_extremum.sv
module scan_extremum #(
  parameter int DW       = 8,
  parameter int AW       = 7,
  parameter bit FIND_MAX = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic          first_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] idx_i,
  output logic [DW-1:0] val_o,
  output logic [AW-1:0] idx_o
);

  logic [DW-1:0] val_q, val_n;
  logic [AW-1:0] idx_q, idx_n;
  logic          better;

  // Strict comparison keeps the earliest position on ties.
  generate
    if (FIND_MAX) begin : g_max
      assign better = (data_i > val_q);
    end else begin : g_min
      assign better = (data_i < val_q);
    end
  endgenerate

  always_comb begin
    val_n = val_q;
    idx_n = idx_q;
    if (valid_i && (first_i || better)) begin
      val_n = data_i;
      idx_n = idx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      idx_q <= '0;
    end else begin
      val_q <= val_n;
      idx_q <= idx_n;
    end
  end

  assign val_o = val_q;
  assign idx_o = idx_q;

endmodule

// File: rtl/array_stat_scan.sv
module array_stat_scan
  import scan_pkg::*;
#(
  parameter  int N_ELEM = 100,
  parameter  int DW     = 8,
  localparam int AW     = idx_width(N_ELEM),
  localparam int SW     = sum_width(DW, N_ELEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_data_i,
  output logic [SW-1:0] sum_o,
  output logic [DW-1:0] max_o,
  output logic [AW-1:0] max_idx_o,
  output logic [DW-1:0] min_o,
  output logic [AW-1:0] min_idx_o,
  output logic          done_o
);

  logic          launch;
  logic          busy;
  logic          rd;
  logic          last;
  logic [AW-1:0] addr;

  // Stage aligned with the returned memory word
  logic          valid_q, valid_n;
  logic          last_q, last_n;
  logic [AW-1:0] idx_q, idx_n;
  logic          done_q, done_n;
  logic          first;

  assign busy   = rd | valid_q;
  assign launch = start_i & ~busy;

  scan_addr_gen #(
    .N_ELEM (N_ELEM),
    .AW     (AW)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .rd_o     (rd),
    .addr_o   (addr),
    .last_o   (last)
  );

  always_comb begin
    valid_n = rd;
    last_n  = last;
    idx_n   = rd ? addr : idx_q;
    done_n  = valid_q & last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= valid_n;
      last_q  <= last_n;
      idx_q   <= idx_n;
      done_q  <= done_n;
    end
  end

  assign first = (idx_q == '0);

  scan_accum #(
    .DW (DW),
    .SW (SW)
  ) u_sum (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_q),
    .first_i (first),
    .data_i  (mem_data_i),
    .sum_o   (sum_o)
  );

  scan_extremum #(
    .DW       (DW),
    .AW       (AW),
    .FIND_MAX (1'b1)
  ) u_max (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_q),
    .first_i (first),
    .data_i  (mem_data_i),
    .idx_i   (idx_q),
    .val_o   (max_o),
    .idx_o   (max_idx_o)
  );

  scan_extremum #(
    .DW       (DW),
    .AW       (AW),
    .FIND_MAX (1'b0)
  ) u_min (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_q),
    .first_i (first),
    .data_i  (mem_data_i),
    .idx_i   (idx_q),
    .val_o   (min_o),
    .idx_o   (min_idx_o)
  );

  assign mem_rd_o   = rd;
  assign mem_addr_o = addr;
  assign done_o     = done_q;

endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
  parameter int N_ELEM = 100,
  parameter int DW     = 8,
  parameter int AW     = 7,
  parameter int SW     = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_i,
  input logic          mem_rd_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [SW-1:0] sum_o,
  input logic [DW-1:0] max_o,
  input logic [AW-1:0] max_idx_o,
  input logic [DW-1:0] min_o,
  input logic [AW-1:0] min_idx_o,
  input logic          done_o
);

  logic accept;
  logic held_q;

  assign accept = start_i & ~busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= 1'b0;
    else if (accept) held_q <= 1'b0;
    else if (done_o) held_q <= 1'b1;
  end

  p_seq_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(1)));

  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_o) |-> (mem_addr_o == '0));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sum_o <= SW'(N_ELEM * ((1 << DW) - 1))));

  p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (max_o >= min_o));

  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((max_idx_o <= AW'(N_ELEM - 1)) && (min_idx_o <= AW'(N_ELEM - 1))));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_o || held_q) && !accept) |=>
      ($stable(sum_o) && $stable(max_o) && $stable(max_idx_o) &&
       $stable(min_o) && $stable(min_idx_o)));

  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && start_i && (mem_addr_o != AW'(N_ELEM - 1))) |=> mem_rd_o);

endmodule

bind array_stat_scan scan_checker #(
  .N_ELEM (N_ELEM),
  .DW     (DW),
  .AW     (AW),
  .SW     (SW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_i     (busy),
  .mem_rd_o   (mem_rd_o),
  .mem_addr_o (mem_addr_o),
  .sum_o      (sum_o),
  .max_o      (max_o),
  .max_idx_o  (max_idx_o),
  .min_o      (min_o),
  .min_idx_o  (min_idx_o),
  .done_o     (done_o)
);

// File: tb/sim_array_stat_scan.sv
`timescale 1ns/1ps
module sim_array_stat_scan;

  localparam int N  = 100;
  localparam int AW = $clog2(N);
  localparam int SW = 8 + $clog2(N);
  localparam int NPAT = 7;
  // kind: 0 ramp up, 1 ramp down, 2 all 0xFF, 3 all zero,
  //       4 hashed, 5 repeating sawtooth, 6 flat with two equal dips
  localparam int PAT_KIND [NPAT] = '{0, 1, 2, 3, 4, 5, 6};
  localparam int PAT_SEED [NPAT] = '{0, 0, 0, 0, 13, 9, 0};
  localparam bit PAT_MID  [NPAT] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data;
  logic [SW-1:0] sum;
  logic [7:0]    maxv, minv;
  logic [AW-1:0] maxi, mini;
  logic          done;

  logic [7:0] mem [N];

  int checks;
  int fails;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_rd) mem_data <= mem[mem_addr];
  end

  array_stat_scan #(.N_ELEM(N), .DW(8)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .mem_rd_o   (mem_rd),
    .mem_addr_o (mem_addr),
    .mem_data_i (mem_data),
    .sum_o      (sum),
    .max_o      (maxv),
    .max_idx_o  (maxi),
    .min_o      (minv),
    .min_idx_o  (mini),
    .done_o     (done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat_val(input int kind, input int seed, input int i);
    case (kind)
      0: return 8'(i);
      1: return 8'(200 - i);
      2: return 8'hFF;
      3: return 8'h00;
      4: return 8'(((i * 37 + seed * 11) ^ (i >> 2)) % 256);
      5: return 8'((i % 10) * seed);
      default: return (i == 50 || i == 80) ? 8'd3 : 8'd50;
    endcase
  endfunction

  task automatic run_case(input int kind, input int seed, input bit mid, input string name);
    longint e_sum;
    int e_max, e_min, e_maxi, e_mini, cnt;
    logic [SW-1:0] s0;
    logic [7:0] a0, b0;
    logic [AW-1:0] ai0, bi0;
    for (int i = 0; i < N; i++) mem[i] = pat_val(kind, seed, i);
    e_sum = 0; e_max = -1; e_min = 256; e_maxi = 0; e_mini = 0;
    for (int i = 0; i < N; i++) begin
      e_sum += mem[i];
      if (int'(mem[i]) > e_max) begin e_max = mem[i]; e_maxi = i; end
      if (int'(mem[i]) < e_min) begin e_min = mem[i]; e_mini = i; end
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cnt = 1;
    while (!done && cnt < 4 * N) begin
      start = (mid && (cnt == 10 || cnt == N)) ? 1'b1 : 1'b0;
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    // R7: done edge is N+1 edges after the accepting edge (count N+2 here)
    chk(cnt == N + 2, {"R7 done latency ", name, mid ? " R9 mid-start" : ""}, cnt, N + 2);
    chk(sum == SW'(e_sum), {"R4 sum ", name}, sum, e_sum);
    chk(maxv == 8'(e_max), {"R5 max ", name}, maxv, e_max);
    chk(maxi == AW'(e_maxi), {"R5 max index ", name}, maxi, e_maxi);
    chk(minv == 8'(e_min), {"R6 min ", name}, minv, e_min);
    chk(mini == AW'(e_mini), {"R6 min index ", name}, mini, e_mini);
    s0 = sum; a0 = maxv; b0 = minv; ai0 = maxi; bi0 = mini;
    @(negedge clk);
    chk(done == 1'b0, {"R7 pulse width ", name}, done, 0);
    repeat (4) @(negedge clk);
    chk(sum == s0 && maxv == a0 && minv == b0 && maxi == ai0 && mini == bi0,
        {"R8 hold ", name}, sum, s0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; start = 1'b0;
    for (int i = 0; i < N; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(done == 0 && mem_rd == 0 && sum == 0, "R10 reset outputs", sum, 0);
    chk(maxv == 0 && minv == 0 && maxi == 0 && mini == 0, "R10 reset extrema", maxv, 0);
    // R1: widths for N=100
    chk($bits(sum) == 15 && $bits(mem_addr) == 7, "R1 widths", $bits(sum), 15);
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < NPAT; p++) begin
      run_case(PAT_KIND[p], PAT_SEED[p], PAT_MID[p], $sformatf("pattern %0d R11", p));
      if (PAT_KIND[p] == 2)
        chk(sum == 15'h639C, "R3 all-FF total", sum, 15'h639C);
    end

    // R2: read strobe count of one pass
    begin
      int rd_cycles;
      rd_cycles = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int c = 0; c < N + 5; c++) begin
        if (mem_rd) rd_cycles++;
        @(negedge clk);
      end
      chk(rd_cycles == N, "R2 read strobe cycles", rd_cycles, N);
    end

    // R10: reset mid-pass abandons it
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(mem_rd == 0 && sum == 0 && done == 0, "R10 reset mid-pass", sum, 0);
    rst_n = 1'b1;
    begin
      bit seen;
      seen = 1'b0;
      for (int c = 0; c < 2 * N; c++) begin
        if (done) seen = 1'b1;
        @(negedge clk);
      end
      chk(!seen, "R10 no done after abandoned pass", seen, 0);
    end

    // R11: recovery with fresh contents
    run_case(2, 0, 1'b0, "R11 rerun after reset");
    chk(sum == 15'h639C, "R3 all-FF total after reset", sum, 15'h639C);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule